// File: doc/BRIEF.md
# ATA Identify Record Checker

This block takes in the 256 sixteen-bit words that a disk drive sends back after an identify request. The words arrive one per cycle on a valid/data stream, in order. The block writes each word into an internal record RAM. While the words arrive, it keeps a running byte sum and latches the capability bits it needs. When the last word lands, it gives a pass or fail verdict. The verdict checks an optional integrity signature with its checksum, and it requires logical block addressing support.

The drive's model name can then be read one character at a time through a small index port. Each stored word holds two characters with the first character in its upper byte. The block swaps them back into reading order. Space padding at the end of the name is replaced by zero bytes, so the string ends where the text ends.

A start pulse clears the results and prepares the block for a new record. If the stream breaks the rules, a sticky protocol-error flag is set. The rule breaks are a word arriving after the record is already complete, or a start pulse arriving partway through a record.

Top module: `ata_ident_checker`

## Requirements
- R1: A record is exactly 256 accepted words. `done_o` rises one clock after the 256th word is accepted and stays low after only 255 words.
- R2: When the low byte of word 255 equals 0xA5, the modulo-256 sum of all 512 bytes of the record must be zero, otherwise the verdict is fail.
- R3: When the low byte of word 255 is not 0xA5, no checksum is applied. A record with the addressing bit set reports pass once all 256 words have arrived.
- R4: A record whose addressing capability bit (word 49, bit 9) is clear reports fail whatever its checksum. `lba_o` reflects that bit.
- R5: `lba48_o` is high only when the 48-bit supported bit (word 83, bit 10) and the 48-bit enabled bit (word 86, bit 10) are both set.
- R6: `dma_o` reports word 49, bit 8 of the completed record.
- R7: The model string is 40 characters held in words 27 to 46. Character 2k is the upper byte of word 27+k and character 2k+1 is its lower byte. `rd_char_o` shows the character selected by `rd_idx_i` two clocks after the index is applied. An index of 40 or more reads as 0x00.
- R8: Trailing spaces (0x20) are read as 0x00. The scan runs backward from character 39 and stops at the first non-space. Character 0 is never replaced, and spaces before the last non-space are kept.
- R9: `proto_err_o` sets when a word arrives after the record is complete, and that word changes no result. It also sets when a start pulse comes after 1 to 255 words. It stays set until the next start pulse that follows an empty or complete record.
- R10: After reset, or one clock after a start pulse, `done_o`, `pass_o`, `fail_o` and the three flags are low. A word presented in the same cycle as a start pulse is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new record and clear results |
| word_valid_i | input | 1 | Word present on `word_i` |
| word_i | input | 16 | Identify record word |
| rd_idx_i | input | 6 | Model string character index |
| done_o | output | 1 | Record complete |
| pass_o | output | 1 | Record accepted |
| fail_o | output | 1 | Record rejected |
| proto_err_o | output | 1 | Stream rule broken (sticky) |
| lba_o | output | 1 | Addressing capability bit |
| lba48_o | output | 1 | 48-bit addressing usable |
| dma_o | output | 1 | DMA capability bit |
| rd_char_o | output | 8 | Model character, trimmed |

## Verification
The bench builds records arithmetically and sweeps every combination of the addressing bit, the DMA bit, the two 48-bit bits, and three signature cases: absent, present with a correct checksum, and present with a checksum off by one. This separates a verdict that ignores the checksum from one that applies it without a signature. For each record it uses a different model length, from all spaces to no padding, with spaces embedded in the text. Reading back every character shows byte-swap mistakes, trimming that stops too early or too late, and the rule that character 0 is never cleared. Short records, an extra word, a mid-record start, and a word presented together with a start show whether the word counting and the protocol flag are handled correctly.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam logic [7:0] PAD_CHAR = 8'h20;
  localparam logic [7:0] SIG_MARK = 8'hA5;

  function automatic logic [7:0] word_bytes_sum(input logic [15:0] w);
    return w[15:8] + w[7:0];
  endfunction
endpackage

// File: rtl/aic_intake.sv
module aic_intake #(
  parameter int WORDS = 256,
  parameter int AW    = 8,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          valid_i,
  output logic          accept_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o,
  output logic          proto_err_o
);
  logic [CW-1:0] count_q;
  logic          full;

  assign full     = (count_q == CW'(WORDS));
  assign accept_o = valid_i && !start_i && !full;
  assign last_o   = accept_o && (count_q == CW'(WORDS - 1));
  assign addr_o   = count_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q     <= '0;
      proto_err_o <= 1'b0;
    end else if (start_i) begin
      count_q     <= '0;
      proto_err_o <= (count_q != '0) && !full;
    end else begin
      if (accept_o) count_q <= count_q + 1'b1;
      if (valid_i && full) proto_err_o <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(WORDS)); // R1
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err_o && !start_i |=> proto_err_o); // R9
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    full && !start_i |=> $stable(count_q)); // R9
endmodule

// File: rtl/aic_judge.sv
module aic_judge
  import aic_pkg::*;
#(
  parameter int AW          = 8,
  parameter int IW          = 6,
  parameter int MODEL_BASE  = 27,
  parameter int MODEL_WORDS = 20,
  parameter int CAPS_WORD   = 49,
  parameter int LBA_BIT     = 9,
  parameter int DMA_BIT     = 8,
  parameter int SUP48_WORD  = 83,
  parameter int EN48_WORD   = 86,
  parameter int EXT_BIT     = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          accept_i,
  input  logic          last_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          lba_o,
  output logic          lba48_o,
  output logic          dma_o,
  output logic [IW-1:0] keep_last_o
);
  logic [7:0]    sum_q, sum_nx;
  logic          lba_p, dma_p, sup_p, en_p;
  logic          in_model, sig_seen, verdict;
  logic [IW-2:0] rel;

  assign sum_nx   = sum_q + word_bytes_sum(data_i);
  assign in_model = (addr_i >= AW'(MODEL_BASE)) &&
                    (addr_i <  AW'(MODEL_BASE + MODEL_WORDS));
  assign rel      = (IW-1)'(addr_i - AW'(MODEL_BASE));
  assign sig_seen = (data_i[7:0] == SIG_MARK);
  assign verdict  = lba_p && (!sig_seen || (sum_nx == 8'h00));

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      sum_q       <= '0;
      lba_p       <= 1'b0;
      dma_p       <= 1'b0;
      sup_p       <= 1'b0;
      en_p        <= 1'b0;
      keep_last_o <= '0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      lba_o       <= 1'b0;
      lba48_o     <= 1'b0;
      dma_o       <= 1'b0;
    end else if (accept_i) begin
      sum_q <= sum_nx;
      if (addr_i == AW'(CAPS_WORD)) begin
        lba_p <= data_i[LBA_BIT];
        dma_p <= data_i[DMA_BIT];
      end
      if (addr_i == AW'(SUP48_WORD)) sup_p <= data_i[EXT_BIT];
      if (addr_i == AW'(EN48_WORD))  en_p  <= data_i[EXT_BIT];
      if (in_model) begin
        if (data_i[7:0] != PAD_CHAR)       keep_last_o <= {rel, 1'b1};
        else if (data_i[15:8] != PAD_CHAR) keep_last_o <= {rel, 1'b0};
      end
      if (last_i) begin
        done_o  <= 1'b1;
        pass_o  <= verdict;
        fail_o  <= !verdict;
        lba_o   <= lba_p;
        lba48_o <= sup_p && en_p;
        dma_o   <= dma_p;
      end
    end
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pass_o ^ fail_o)); // R2
  AST_NO_LBA_FAIL: assert property (@(posedge clk) disable iff (rst)
    done_o && !lba_o |-> fail_o); // R4
  AST_EXT_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    lba48_o |-> done_o); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !done_o && !pass_o && !fail_o); // R10
endmodule

// File: rtl/aic_string_port.sv
module aic_string_port #(
  parameter int WORDS      = 256,
  parameter int AW         = 8,
  parameter int MODEL_BASE = 27,
  parameter int NCHAR      = 40,
  parameter int IW         = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [15:0]   wdata_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [IW-1:0] keep_last_i,
  output logic [7:0]    rd_char_o
);
  logic [15:0]   mem [WORDS];
  logic [15:0]   mem_q;
  logic [AW-1:0] raddr;
  logic          hi_q, keep_q, keep;

  assign raddr = AW'(MODEL_BASE) + AW'(rd_idx_i[IW-1:1]);
  assign keep  = ({1'b0, rd_idx_i} < (IW+1)'(NCHAR)) && (rd_idx_i <= keep_last_i);

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= 1'b0;
      keep_q    <= 1'b0;
      rd_char_o <= '0;
    end else begin
      hi_q      <= !rd_idx_i[0];
      keep_q    <= keep;
      rd_char_o <= keep_q ? (hi_q ? mem_q[15:8] : mem_q[7:0]) : 8'h00;
    end
  end

  AST_TRIM_ZERO: assert property (@(posedge clk) disable iff (rst)
    !keep_q |=> (rd_char_o == 8'h00)); // R8
  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, rd_idx_i} >= (IW+1)'(NCHAR)) |=> !keep_q); // R7
endmodule

// File: rtl/ata_ident_checker.sv
module ata_ident_checker #(
  parameter int WORDS       = 256,
  parameter int MODEL_BASE  = 27,
  parameter int MODEL_WORDS = 20,
  parameter int CAPS_WORD   = 49,
  parameter int LBA_BIT     = 9,
  parameter int DMA_BIT     = 8,
  parameter int SUP48_WORD  = 83,
  parameter int EN48_WORD   = 86,
  parameter int EXT_BIT     = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start_i,
  input  logic                             word_valid_i,
  input  logic [15:0]                      word_i,
  input  logic [$clog2(2*MODEL_WORDS)-1:0] rd_idx_i,
  output logic                             done_o,
  output logic                             pass_o,
  output logic                             fail_o,
  output logic                             proto_err_o,
  output logic                             lba_o,
  output logic                             lba48_o,
  output logic                             dma_o,
  output logic [7:0]                       rd_char_o
);
  localparam int AW    = $clog2(WORDS);
  localparam int CW    = $clog2(WORDS + 1);
  localparam int NCHAR = 2 * MODEL_WORDS;
  localparam int IW    = $clog2(NCHAR);

  logic          accept, last;
  logic [AW-1:0] addr;
  logic [IW-1:0] keep_last;

  aic_intake #(.WORDS(WORDS), .AW(AW), .CW(CW)) u_intake (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(word_valid_i),
    .accept_o(accept), .last_o(last), .addr_o(addr), .proto_err_o(proto_err_o)
  );

  aic_judge #(
    .AW(AW), .IW(IW), .MODEL_BASE(MODEL_BASE), .MODEL_WORDS(MODEL_WORDS),
    .CAPS_WORD(CAPS_WORD), .LBA_BIT(LBA_BIT), .DMA_BIT(DMA_BIT),
    .SUP48_WORD(SUP48_WORD), .EN48_WORD(EN48_WORD), .EXT_BIT(EXT_BIT)
  ) u_judge (
    .clk(clk), .rst(rst), .start_i(start_i), .accept_i(accept), .last_i(last),
    .addr_i(addr), .data_i(word_i), .done_o(done_o), .pass_o(pass_o),
    .fail_o(fail_o), .lba_o(lba_o), .lba48_o(lba48_o), .dma_o(dma_o),
    .keep_last_o(keep_last)
  );

  aic_string_port #(
    .WORDS(WORDS), .AW(AW), .MODEL_BASE(MODEL_BASE), .NCHAR(NCHAR), .IW(IW)
  ) u_string (
    .clk(clk), .rst(rst), .we_i(accept), .waddr_i(addr), .wdata_i(word_i),
    .rd_idx_i(rd_idx_i), .keep_last_i(keep_last), .rd_char_o(rd_char_o)
  );

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(word_valid_i && !start_i)); // R1
  AST_IGNORE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> $stable(pass_o) && done_o); // R9
endmodule

// File: tb/ata_ident_checker_bench.sv
module ata_ident_checker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [15:0] word_i = '0;
  logic [5:0]  rd_idx_i = '0;
  logic done_o, pass_o, fail_o, proto_err_o, lba_o, lba48_o, dma_o;
  logic [7:0]  rd_char_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] rec [256];
  logic [7:0]  chr [40];

  always #5 clk = ~clk;

  ata_ident_checker u_ata_ident_checker (
    .clk(clk), .rst(rst), .start_i(start_i), .word_valid_i(word_valid_i),
    .word_i(word_i), .rd_idx_i(rd_idx_i), .done_o(done_o), .pass_o(pass_o),
    .fail_o(fail_o), .proto_err_o(proto_err_o), .lba_o(lba_o),
    .lba48_o(lba48_o), .dma_o(dma_o), .rd_char_o(rd_char_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input bit lba, input bit dma, input bit sup, input bit en,
                       input int sigmode, input int len, input int seed);
    logic [7:0] s;
    for (int i = 0; i < 256; i++) rec[i] = 16'(i * 1103 + seed * 77 + 9);
    for (int i = 0; i < 40; i++) begin
      if (i >= len) chr[i] = 8'h20;
      else if (i % 7 == 3) chr[i] = 8'h20;
      else chr[i] = 8'h41 + 8'((i + seed) % 26);
    end
    for (int k = 0; k < 20; k++) rec[27 + k] = {chr[2*k], chr[2*k+1]};
    rec[49] = (rec[49] & 16'hFCFF) | {6'd0, lba, dma, 8'd0};
    rec[83] = (rec[83] & 16'hFBFF) | {5'd0, sup, 10'd0};
    rec[86] = (rec[86] & 16'hFBFF) | {5'd0, en, 10'd0};
    rec[255][7:0] = (sigmode == 0) ? 8'h5A : 8'hA5;
    s = rec[255][7:0];
    for (int i = 0; i < 255; i++) s = s + rec[i][15:8] + rec[i][7:0];
    if (sigmode == 0) rec[255][15:8] = 8'h33;
    else if (sigmode == 1) rec[255][15:8] = 8'h00 - s;
    else rec[255][15:8] = 8'h01 - s;
  endtask

  task automatic pulse_start(input bit with_word);
    @(negedge clk);
    start_i = 1'b1;
    word_valid_i = with_word;
    word_i = 16'hBEEF;
    @(negedge clk);
    start_i = 1'b0;
    word_valid_i = 1'b0;
  endtask

  task automatic send(input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      @(negedge clk);
      word_valid_i = 1'b1;
      word_i = rec[i];
    end
    @(negedge clk);
    word_valid_i = 1'b0;
  endtask

  task automatic read_char(input int idx, output logic [7:0] c);
    rd_idx_i = 6'(idx);
    @(negedge clk);
    @(negedge clk);
    c = rd_char_o;
  endtask

  task automatic check_string();
    int last;
    logic [7:0] got, exp;
    last = 0;
    for (int i = 39; i > 0; i--) if (last == 0 && chr[i] != 8'h20) last = i;
    for (int i = 0; i < 40; i++) begin
      read_char(i, got);
      exp = (i <= last) ? chr[i] : 8'h00;
      check(got == exp, (i <= last) ? "R7 model char" : "R8 trimmed char", got, exp);
    end
    read_char(40, got);
    check(got == 8'h00, "R7 index 40", got, 0);
    read_char(63, got);
    check(got == 8'h00, "R7 index 63", got, 0);
  endtask

  task automatic check_result(input bit lba, input bit dma, input bit sup, input bit en,
                              input int sigmode);
    bit exp_pass;
    exp_pass = lba && (sigmode != 2);
    check(done_o == 1'b1, "R1 done after 256", done_o, 1);
    if (sigmode == 0)
      check(pass_o == exp_pass, "R3 verdict without signature", pass_o, exp_pass);
    else
      check(pass_o == exp_pass, "R2 checksum verdict", pass_o, exp_pass);
    check(fail_o == !exp_pass, "R4 fail flag", fail_o, !exp_pass);
    check(lba_o == lba, "R4 lba flag", lba_o, lba);
    check(lba48_o == (sup && en), "R5 lba48 usable", lba48_o, sup && en);
    check(dma_o == dma, "R6 dma flag", dma_o, dma);
    check(proto_err_o == 1'b0, "R9 no protocol error", proto_err_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int idx;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({done_o, pass_o, fail_o, proto_err_o, lba_o, lba48_o, dma_o} == 7'd0,
          "R10 reset state", {done_o, pass_o, fail_o}, 0);

    // Sweep all flag combinations and three signature cases
    idx = 0;
    for (int l = 0; l < 2; l++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          for (int e = 0; e < 2; e++)
            for (int g = 0; g < 3; g++) begin
              build(l[0], d[0], s[0], e[0], g, (idx * 7) % 41, idx);
              pulse_start(1'b0);
              check(done_o == 1'b0, "R10 start clears done", done_o, 0);
              send(0, 256);
              check_result(l[0], d[0], s[0], e[0], g);
              if (idx % 4 == 0) check_string();
              idx++;
            end

    // Full-length model with no padding, and an all-space model
    build(1, 0, 1, 1, 0, 40, 3);
    pulse_start(1'b0);
    send(0, 256);
    check_result(1, 0, 1, 1, 0);
    check_string();
    build(1, 1, 0, 0, 1, 0, 5);
    pulse_start(1'b0);
    send(0, 256);
    check_result(1, 1, 0, 0, 1);
    check_string();

    // R1: 255 words do not complete; R9: start mid-record flags error
    build(1, 0, 0, 0, 0, 12, 8);
    pulse_start(1'b0);
    send(0, 255);
    check(done_o == 1'b0, "R1 no done after 255", done_o, 0);
    pulse_start(1'b0);
    check(proto_err_o == 1'b1, "R9 start mid-record", proto_err_o, 1);
    check(done_o == 1'b0, "R10 cleared after start", done_o, 0);
    send(0, 256);
    check(done_o == 1'b1 && pass_o == 1'b1, "R3 pass after restart", pass_o, 1);
    check(proto_err_o == 1'b1, "R9 error sticky", proto_err_o, 1);

    // R9: extra word after completion is ignored
    build(0, 0, 0, 0, 0, 12, 9);
    pulse_start(1'b0);
    check(proto_err_o == 1'b0, "R9 start after complete clears", proto_err_o, 1'b0);
    send(0, 256);
    prev = fail_o;
    check(prev == 1'b1, "R4 no lba fails", fail_o, 1);
    rec[0] = 16'h0000;
    send(0, 1);
    check(proto_err_o == 1'b1, "R9 word after complete", proto_err_o, 1);
    check(fail_o == prev && done_o == 1'b1 && pass_o == 1'b0, "R9 result unchanged",
          fail_o, prev);

    // R10: word alongside start is discarded
    build(1, 1, 1, 0, 1, 20, 11);
    pulse_start(1'b1);
    send(0, 255);
    check(done_o == 1'b0, "R10 word with start discarded", done_o, 0);
    send(255, 1);
    check_result(1, 1, 1, 0, 1);
    check_string();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule